// File: doc/BRIEF.md
# Coalesced Periodic-Interrupt EOI Tracker

This block sits beside an interrupt router and watches a single edge-triggered source whose consumers need to know whether the previous interrupt has been fully handled. When the source fires and the tracker is idle, the block lets delivery go ahead. It then records which CPUs accepted the interrupt and the vector sent to each one, and it loads a count of outstanding end-of-interrupt acknowledgements. While that count is non-zero, any new assertion of the source is flagged as coalesced and is not delivered.

The routing logic computes the accepted-destination bitmap and presents it in the same cycle as the assertion request, together with a success flag. CPUs report end-of-interrupt events as a CPU number and a vector. An event retires a destination only if that CPU's bit is set and the vector matches the one recorded for it. The count can disagree with the bitmap, for example after a failed delivery that still marked destinations. If a matching event would then drive the count below zero, the tracker rebuilds its whole state in one cycle from a scan input that lists which CPUs still hold the vector pending.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: A synchronous active-high reset clears the outstanding count and every bit of the destination bitmap.
- R2: When `req_assert` is high and the outstanding count is non-zero, `coalesced` is high and `deliver_go` is low. No delivery is recorded, so the count and bitmap change only through an end-of-interrupt event accepted in that cycle.
- R3: When `req_assert` is high and the count is zero, `deliver_go` is high. On the next edge the count becomes the number of set bits in `accept_map` if `dlv_ok` is 1, or 0 if `dlv_ok` is 0. Every CPU whose bit in `accept_map` is set gets its bitmap bit set, with `accept_map` bit i standing for CPU i.
- R4: An accepted end-of-interrupt event for CPU c with vector v clears bit c and lowers the count by one, provided bit c is set, v equals the vector recorded for c, and the count is non-zero.
- R5: An end-of-interrupt event has no effect on the count or the bitmap if the CPU's bit is clear, if its vector differs from the recorded one, or if `eoi_cpu` is N or larger. With neither a delivery nor an event, the state holds.
- R6: A matching end-of-interrupt event that arrives while the count is zero rebuilds the state instead. The bitmap is loaded from `scan_map`, each CPU set in `scan_map` records `scan_vector`, and the count becomes the number of set bits in `scan_map`.
- R7: In a cycle where `deliver_go` is high, `eoi_ready` is low and any presented event is not applied. The source keeps the event and it takes effect in a later cycle with `eoi_ready` high.
- R8: Each CPU keeps its own recorded vector. A delivery rewrites the vector only for CPUs set in `accept_map`, and the others keep the vector from an earlier delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_assert | input | 1 | New edge on the tracked source |
| dlv_ok | input | 1 | Delivery succeeded (valid with req_assert) |
| accept_map | input | N | CPUs that accepted the delivery |
| dlv_vector | input | 8 | Vector sent with the delivery |
| eoi_valid | input | 1 | End-of-interrupt event present |
| eoi_cpu | input | clog2(N)+1 | CPU issuing the event |
| eoi_vector | input | 8 | Vector being acknowledged |
| scan_map | input | N | CPUs still holding the vector pending (rebuild source) |
| scan_vector | input | 8 | Vector recorded for CPUs rebuilt from the scan |
| deliver_go | output | 1 | Assertion accepted for delivery this cycle |
| coalesced | output | 1 | Assertion refused because acknowledgements are outstanding |
| eoi_ready | output | 1 | Event can be applied this cycle |
| outstanding | output | clog2(N+1) | Outstanding acknowledgement count |
| dest_map | output | N | Destinations still awaiting acknowledgement |

## Verification
The bench sends acknowledgements that each miss on exactly one condition: a wrong vector, a clear bit, or a CPU number beyond N. A tracker that skipped any one of those tests would drop the count early and let a coalesced edge through. It runs a failed delivery that still marks destinations and then acknowledges one of them with the count already at zero. A design without the rebuild path would wrap the count to its maximum, and one that rebuilt from the wrong source would show the wrong bitmap. It also presents an acknowledgement in the same cycle as a delivery. A design that let the event through would leave the count one short. A second delivery then overlaps CPUs from an earlier one, to show that vectors are rewritten only for the newly accepted CPUs.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

    localparam int VEC_W = 8;

    typedef logic [VEC_W-1:0] vec_t;

    // One state-changing action per cycle, chosen by the controller.
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_RECORD  = 2'd1,
        ACT_RETIRE  = 2'd2,
        ACT_REBUILD = 2'd3
    } act_e;

    // A slot matches an event when it is armed and holds the same vector.
    function automatic logic slot_match(input logic armed, input vec_t held, input vec_t seen);
        return armed && (held == seen);
    endfunction

endpackage

// File: rtl/eoi_trk_bank.sv
module eoi_trk_bank
    import eoi_trk_pkg::*;
#(
    parameter int N    = 8,
    parameter int CIDW = $clog2(N) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  act_e            act,
    input  logic [N-1:0]    accept_map,
    input  vec_t            dlv_vector,
    input  logic [CIDW-1:0] eoi_cpu,
    input  vec_t            eoi_vector,
    input  logic [N-1:0]    scan_map,
    input  vec_t            scan_vector,
    output logic [N-1:0]    armed_map,
    output logic            hit
);

    logic [N-1:0] slot_hit;

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic armed_q;
        vec_t vec_q;
        logic sel;

        assign sel         = (eoi_cpu == CIDW'(i));
        assign slot_hit[i] = sel && slot_match(armed_q, vec_q, eoi_vector);
        assign armed_map[i] = armed_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                armed_q <= 1'b0;
                vec_q   <= '0;
            end else begin
                unique case (act)
                    ACT_RECORD: begin
                        if (accept_map[i]) begin
                            armed_q <= 1'b1;
                            vec_q   <= dlv_vector;
                        end
                    end
                    ACT_RETIRE: begin
                        if (sel) armed_q <= 1'b0;
                    end
                    ACT_REBUILD: begin
                        armed_q <= scan_map[i];
                        if (scan_map[i]) vec_q <= scan_vector;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/eoi_trk_ctrl.sv
module eoi_trk_ctrl
    import eoi_trk_pkg::*;
#(
    parameter int N    = 8,
    parameter int CNTW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_assert,
    input  logic            dlv_ok,
    input  logic [N-1:0]    accept_map,
    input  logic            eoi_valid,
    input  logic            hit,
    input  logic [N-1:0]    scan_map,
    output act_e            act,
    output logic            deliver_go,
    output logic            coalesced,
    output logic            eoi_ready,
    output logic [CNTW-1:0] outstanding
);

    logic [CNTW-1:0] cnt_q;
    logic            busy;

    assign busy       = (cnt_q != '0);
    assign deliver_go = req_assert && !busy;
    assign coalesced  = req_assert && busy;
    // Delivery owns the cycle; an event presented alongside it waits.
    assign eoi_ready  = !deliver_go;

    always_comb begin
        act = ACT_IDLE;
        if (deliver_go)
            act = ACT_RECORD;
        else if (eoi_valid && hit)
            act = busy ? ACT_RETIRE : ACT_REBUILD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                ACT_RECORD:  cnt_q <= dlv_ok ? CNTW'($countones(accept_map)) : '0;
                ACT_RETIRE:  cnt_q <= cnt_q - 1'b1;
                ACT_REBUILD: cnt_q <= CNTW'($countones(scan_map));
                default: ;
            endcase
        end
    end

    assign outstanding = cnt_q;

endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker
    import eoi_trk_pkg::*;
#(
    parameter  int N    = 8,
    localparam int CIDW = $clog2(N) + 1,
    localparam int CNTW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_assert,
    input  logic            dlv_ok,
    input  logic [N-1:0]    accept_map,
    input  logic [VEC_W-1:0] dlv_vector,
    input  logic            eoi_valid,
    input  logic [CIDW-1:0] eoi_cpu,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic [N-1:0]    scan_map,
    input  logic [VEC_W-1:0] scan_vector,
    output logic            deliver_go,
    output logic            coalesced,
    output logic            eoi_ready,
    output logic [CNTW-1:0] outstanding,
    output logic [N-1:0]    dest_map
);

    act_e act;
    logic hit;

    eoi_trk_ctrl #(.N(N), .CNTW(CNTW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_assert (req_assert),
        .dlv_ok     (dlv_ok),
        .accept_map (accept_map),
        .eoi_valid  (eoi_valid),
        .hit        (hit),
        .scan_map   (scan_map),
        .act        (act),
        .deliver_go (deliver_go),
        .coalesced  (coalesced),
        .eoi_ready  (eoi_ready),
        .outstanding(outstanding)
    );

    eoi_trk_bank #(.N(N), .CIDW(CIDW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .accept_map (accept_map),
        .dlv_vector (dlv_vector),
        .eoi_cpu    (eoi_cpu),
        .eoi_vector (eoi_vector),
        .scan_map   (scan_map),
        .scan_vector(scan_vector),
        .armed_map  (dest_map),
        .hit        (hit)
    );

endmodule

// File: rtl/eoi_trk_chk.sv
module eoi_trk_chk #(
    parameter  int N    = 8,
    localparam int CNTW = $clog2(N + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            req_assert,
    input logic            dlv_ok,
    input logic [N-1:0]    accept_map,
    input logic            eoi_valid,
    input logic            deliver_go,
    input logic            coalesced,
    input logic [CNTW-1:0] outstanding,
    input logic [N-1:0]    dest_map
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (outstanding == '0 && dest_map == '0));

    // R2
    coalesce_hold_chk: assert property (@(posedge clk) disable iff (rst)
        coalesced && !eoi_valid |=> $stable(outstanding) && $stable(dest_map));

    // R3
    load_ok_chk: assert property (@(posedge clk) disable iff (rst)
        deliver_go && dlv_ok |=> outstanding == CNTW'($countones($past(accept_map))));

    // R3
    load_fail_chk: assert property (@(posedge clk) disable iff (rst)
        deliver_go && !dlv_ok |=> outstanding == '0);

    // R7
    eoi_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        deliver_go |=> dest_map == ($past(dest_map) | $past(accept_map)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_assert && !eoi_valid |=> $stable(outstanding) && $stable(dest_map));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        outstanding <= CNTW'(N));

endmodule

bind eoi_coalesce_tracker eoi_trk_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_assert (req_assert),
    .dlv_ok     (dlv_ok),
    .accept_map (accept_map),
    .eoi_valid  (eoi_valid),
    .deliver_go (deliver_go),
    .coalesced  (coalesced),
    .outstanding(outstanding),
    .dest_map   (dest_map)
);

// File: tb/eoi_coalesce_tracker_test.sv
`timescale 1ns/1ps
module eoi_coalesce_tracker_test;

    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_assert = 1'b0, dlv_ok = 1'b0;
    logic [7:0] accept_map = '0, dlv_vector = '0;
    logic       eoi_valid = 1'b0;
    logic [3:0] eoi_cpu = '0;
    logic [7:0] eoi_vector = '0, scan_map = '0, scan_vector = '0;
    logic       deliver_go, coalesced, eoi_ready;
    logic [3:0] outstanding;
    logic [7:0] dest_map;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    eoi_coalesce_tracker #(.N(N)) uut (
        .clk(clk), .rst(rst), .req_assert(req_assert), .dlv_ok(dlv_ok),
        .accept_map(accept_map), .dlv_vector(dlv_vector), .eoi_valid(eoi_valid),
        .eoi_cpu(eoi_cpu), .eoi_vector(eoi_vector), .scan_map(scan_map),
        .scan_vector(scan_vector), .deliver_go(deliver_go), .coalesced(coalesced),
        .eoi_ready(eoi_ready), .outstanding(outstanding), .dest_map(dest_map)
    );

    typedef struct {
        string      tag;
        logic       go, coal, rdy;
        int         cnt;
        logic [7:0] map;
    } item_t;

    item_t q[$];

    // Independent model of the requirements
    logic [7:0] ref_map;
    logic [7:0] ref_vec [N];
    int         ref_cnt;

    task automatic ref_clear();
        ref_map = '0;
        ref_cnt = 0;
        for (int i = 0; i < N; i++) ref_vec[i] = '0;
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic rq, input logic ok,
                         input logic [7:0] acc, input logic [7:0] vec,
                         input logic ev, input logic [3:0] ec, input logic [7:0] evv,
                         input logic [7:0] smap, input logic [7:0] svec);
        item_t it;
        @(negedge clk);
        req_assert = rq; dlv_ok = ok; accept_map = acc; dlv_vector = vec;
        eoi_valid = ev; eoi_cpu = ec; eoi_vector = evv;
        scan_map = smap; scan_vector = svec;
        it.tag  = tag;
        it.go   = rq && (ref_cnt == 0);
        it.coal = rq && (ref_cnt != 0);
        it.rdy  = !it.go;
        if (it.go) begin
            for (int i = 0; i < N; i++)
                if (acc[i]) begin ref_map[i] = 1'b1; ref_vec[i] = vec; end
            ref_cnt = ok ? $countones(acc) : 0;
        end else if (ev && ec < N && ref_map[ec[2:0]] && ref_vec[ec[2:0]] == evv) begin
            if (ref_cnt == 0) begin
                ref_map = smap;
                for (int i = 0; i < N; i++) if (smap[i]) ref_vec[i] = svec;
                ref_cnt = $countones(smap);
            end else begin
                ref_map[ec[2:0]] = 1'b0;
                ref_cnt--;
            end
        end
        it.cnt = ref_cnt;
        it.map = ref_map;
        q.push_back(it);
    endtask

    // Monitor: outputs that depend on this cycle's inputs before the edge, state after it
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                check(it.tag, "deliver_go", int'(deliver_go), int'(it.go));
                check(it.tag, "coalesced",  int'(coalesced),  int'(it.coal));
                check(it.tag, "eoi_ready",  int'(eoi_ready),  int'(it.rdy));
                @(posedge clk);
                #1;
                check(it.tag, "outstanding", int'(outstanding), it.cnt);
                check(it.tag, "dest_map",    int'(dest_map),    int'(it.map));
            end
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic drain();
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        ref_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: state after reset
        drive("R1 idle after reset", 0, 0, 8'h00, 8'h00, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        // R3 R8: delivery to CPUs 0 and 2
        drive("R3 first delivery", 1, 1, 8'h05, 8'h31, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        // R2: repeat edge coalesced
        drive("R2 coalesced edge", 1, 1, 8'hF0, 8'h99, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        // R5: wrong vector, clear bit, CPU out of range
        drive("R5 vector mismatch", 0, 0, 8'h00, 8'h00, 1, 4'd0, 8'h30, 8'hFF, 8'h00);
        drive("R5 bit clear", 0, 0, 8'h00, 8'h00, 1, 4'd1, 8'h31, 8'hFF, 8'h00);
        drive("R5 cpu out of range", 0, 0, 8'h00, 8'h00, 1, 4'd9, 8'h31, 8'hFF, 8'h00);
        // R4: matching acknowledgement
        drive("R4 retire cpu0", 0, 0, 8'h00, 8'h00, 1, 4'd0, 8'h31, 8'h00, 8'h00);
        // R2 R4: coalesced edge alongside last acknowledgement
        drive("R2 coalesced with eoi", 1, 1, 8'hFF, 8'h11, 1, 4'd2, 8'h31, 8'h00, 8'h00);
        // R7: delivery and event in one cycle, event retried next cycle
        drive("R7 delivery wins", 1, 1, 8'h0A, 8'h40, 1, 4'd1, 8'h40, 8'h00, 8'h00);
        drive("R7 eoi retried", 0, 0, 8'h00, 8'h00, 1, 4'd1, 8'h40, 8'h00, 8'h00);
        drive("R4 retire cpu3", 0, 0, 8'h00, 8'h00, 1, 4'd3, 8'h40, 8'h00, 8'h00);
        // R3: failed delivery marks bits, count stays zero
        drive("R3 failed delivery", 1, 0, 8'h30, 8'h66, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        // R8: next delivery rewrites only CPU0
        drive("R8 partial overwrite", 1, 1, 8'h01, 8'h77, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        drive("R8 cpu4 kept old vector", 0, 0, 8'h00, 8'h00, 1, 4'd4, 8'h66, 8'h00, 8'h00);
        // R6: matching event at count zero rebuilds from scan
        drive("R6 rebuild", 0, 0, 8'h00, 8'h00, 1, 4'd5, 8'h66, 8'h06, 8'h12);
        drive("R6 rebuilt vector cpu1", 0, 0, 8'h00, 8'h00, 1, 4'd1, 8'h12, 8'h00, 8'h00);
        drive("R5 rebuilt cpu2 mismatch", 0, 0, 8'h00, 8'h00, 1, 4'd2, 8'h77, 8'h00, 8'h00);
        drive("R6 rebuilt vector cpu2", 0, 0, 8'h00, 8'h00, 1, 4'd2, 8'h12, 8'h00, 8'h00);
        // R3: every CPU accepts
        drive("R3 full delivery", 1, 1, 8'hFF, 8'h01, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        drain();

        // R1: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1; req_assert = 0; eoi_valid = 0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", "outstanding", int'(outstanding), 0);
        check("R1 mid-run reset", "dest_map", int'(dest_map), 0);
        ref_clear();
        @(negedge clk) rst = 1'b0;
        drive("R3 delivery after reset", 1, 1, 8'h81, 8'h22, 0, 4'd0, 8'h00, 8'h00, 8'h00);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule